// File: doc/BRIEF.md
# Three-Channel Gated High-Side Switch Controller

This block turns software enable bits into gate-enable signals for three high-side load switches. The first two channels are meant for relays or lamps that a host may dim or pulse. Their gates are qualified by a direct PWM pin. When that pin is held high, the enable bits alone decide the state of those two channels. The third channel serves a small load such as a sensor supply, and it follows its enable bit only. All gates are held off unless the device operating mode is one of the two normal modes.

Each channel has its own two-state machine. In `SW_ARMED` the gate may conduct. A thermal fault input moves the channel to `SW_TRIPPED` (transition *thermal trip*). The channel stays there even after the fault input drops. It returns to `SW_ARMED` (transition *rearm*) only on a register write that carries a 1 in its enable bit while its fault input is low. If the same write arrives while the fault is still present, the channel stays tripped (transition *re-trip*), and this counts as a new shutdown. Each entry into `SW_TRIPPED` and each re-trip raises a one-cycle event for the interrupt logic. A combined status bit shows whether any channel is tripped.

Top module: `hs_gate_ctrl`

## Requirements
- R1: In an allowed mode, an armed channel 0 or 1 with its fault input low drives gate_o[k] = en_bits_i[k] AND pwm_i, combinationally.
- R2: In an allowed mode, an armed channel 2 with its fault input low drives gate_o[2] = en_bits_i[2], and pwm_i has no effect on it. No gate is ever high while its enable bit is 0.
- R3: dev_mode_i codes are 0 reset, 1 normal-request, 2 normal, 3 stop and 4 sleep; codes 5 to 7 are unused. All gates are 0 unless dev_mode_i is 1 or 2.
- R4: While ot_i[k] is 1, gate_o[k] is 0 in that same cycle. If the channel was armed at the clock edge, it becomes tripped, and gate_o[k] then stays 0 after ot_i[k] falls.
- R5: A tripped channel k rearms at a clock edge only when wr_stb_i is 1, en_bits_i[k] is 1 and ot_i[k] is 0 at that edge. A write with en_bits_i[k] = 0, or en_bits_i[k] = 1 held without a strobe, leaves the channel tripped.
- R6: A write with en_bits_i[k] = 1 that arrives while ot_i[k] is still 1 leaves channel k tripped and raises fault_evt_o in the next cycle.
- R7: ot_stat_o is 1 exactly while at least one channel is tripped. It is updated at the clock edge.
- R8: fault_evt_o is 1 for one cycle after each edge at which a channel trips or re-trips. A fault input that stays high on an already tripped channel raises no further event.
- R9: After reset all channels are armed, and ot_stat_o and fault_evt_o are 0.
- R10: Trip and rearm act on each channel on its own. A fault or rewrite on one channel leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_mode_i | input | 3 | Device operating mode code (see R3) |
| en_bits_i | input | NUM_SW | Switch enable bits from the register file |
| wr_stb_i | input | 1 | One-cycle pulse: en_bits_i was written this cycle |
| pwm_i | input | 1 | Direct PWM pin for the gated channels |
| ot_i | input | NUM_SW | Per-channel over-temperature indication |
| gate_o | output | NUM_SW | Gate enable per switch |
| ot_stat_o | output | 1 | Any channel latched off for over-temperature |
| fault_evt_o | output | 1 | One-cycle thermal shutdown event |

## Verification
The assertions assume that dev_mode_i, en_bits_i, pwm_i, ot_i and wr_stb_i are synchronous to clk and settle before each edge. They also assume that wr_stb_i appears together with the written enable value. The stimulus changes every input just after a rising edge. It draws modes mostly from the two normal codes so that gating is exercised. It keeps thermal events sparse, so that trips, held faults, rewrites under a fault and clean rearms all occur. Directed cycles cover the trip and rearm corners before the random phase.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [2:0] {
        MD_RESET    = 3'd0,
        MD_NORM_REQ = 3'd1,
        MD_NORMAL   = 3'd2,
        MD_STOP     = 3'd3,
        MD_SLEEP    = 3'd4
    } hs_mode_e;

    typedef enum logic {
        SW_ARMED   = 1'b0,
        SW_TRIPPED = 1'b1
    } hs_sw_state_e;

endpackage

// File: rtl/hs_mode_gate.sv
module hs_mode_gate
    import hs_pkg::*;
(
    input  logic [2:0] mode_i,
    output logic       allow_o
);

    hs_mode_e mode;
    assign mode = hs_mode_e'(mode_i);

    always_comb begin
        unique case (mode)
            MD_NORM_REQ,
            MD_NORMAL:   allow_o = 1'b1;
            MD_RESET,
            MD_STOP,
            MD_SLEEP:    allow_o = 1'b0;
            default:     allow_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/hs_sw_fsm.sv
module hs_sw_fsm
    import hs_pkg::*;
#(
    parameter bit PWM_GATED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic allow_i,
    input  logic en_i,
    input  logic wr_i,
    input  logic pwm_i,
    input  logic ot_i,
    output logic gate_o,
    output logic tripped_o,
    output logic evt_o
);

    localparam logic PWM_BYPASS = !PWM_GATED;

    hs_sw_state_e state_q, state_d;
    logic         evt_q, evt_d;
    logic         rewrite;
    logic         pwm_ok;

    assign rewrite = wr_i && en_i;
    assign pwm_ok  = pwm_i | PWM_BYPASS;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_ARMED;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            evt_q   <= evt_d;
        end
    end

    // transitions: thermal trip, rearm, re-trip
    always_comb begin
        state_d = state_q;
        evt_d   = 1'b0;
        unique case (state_q)
            SW_ARMED: begin
                if (ot_i) begin
                    state_d = SW_TRIPPED;
                    evt_d   = 1'b1;
                end
            end
            SW_TRIPPED: begin
                if (rewrite) begin
                    if (ot_i) begin
                        evt_d = 1'b1;
                    end else begin
                        state_d = SW_ARMED;
                    end
                end
            end
            default: state_d = SW_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        gate_o    = 1'b0;
        tripped_o = 1'b0;
        unique case (state_q)
            SW_ARMED:   gate_o = allow_i && en_i && pwm_ok && !ot_i;
            SW_TRIPPED: tripped_o = 1'b1;
            default:    tripped_o = 1'b1;
        endcase
    end

    assign evt_o = evt_q;

endmodule

// File: rtl/hs_fault_merge.sv
module hs_fault_merge #(
    parameter int NUM_SW = 3
) (
    input  logic [NUM_SW-1:0] tripped_i,
    input  logic [NUM_SW-1:0] evt_i,
    output logic              stat_o,
    output logic              evt_o
);

    assign stat_o = |tripped_i;
    assign evt_o  = |evt_i;

endmodule

// File: rtl/hs_gate_ctrl.sv
module hs_gate_ctrl #(
    parameter int                NUM_SW   = 3,
    parameter logic [NUM_SW-1:0] PWM_MASK = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        dev_mode_i,
    input  logic [NUM_SW-1:0] en_bits_i,
    input  logic              wr_stb_i,
    input  logic              pwm_i,
    input  logic [NUM_SW-1:0] ot_i,
    output logic [NUM_SW-1:0] gate_o,
    output logic              ot_stat_o,
    output logic              fault_evt_o
);

    logic              allow;
    logic [NUM_SW-1:0] tripped;
    logic [NUM_SW-1:0] evt;

    hs_mode_gate u_mode (
        .mode_i  (dev_mode_i),
        .allow_o (allow)
    );

    for (genvar k = 0; k < NUM_SW; k++) begin : g_sw
        hs_sw_fsm #(
            .PWM_GATED (PWM_MASK[k])
        ) u_sw (
            .clk       (clk),
            .rst_n     (rst_n),
            .allow_i   (allow),
            .en_i      (en_bits_i[k]),
            .wr_i      (wr_stb_i),
            .pwm_i     (pwm_i),
            .ot_i      (ot_i[k]),
            .gate_o    (gate_o[k]),
            .tripped_o (tripped[k]),
            .evt_o     (evt[k])
        );
    end

    hs_fault_merge #(
        .NUM_SW (NUM_SW)
    ) u_merge (
        .tripped_i (tripped),
        .evt_i     (evt),
        .stat_o    (ot_stat_o),
        .evt_o     (fault_evt_o)
    );

endmodule

// File: rtl/hs_gate_ctrl_chk.sv
module hs_gate_ctrl_chk #(
    parameter int                NUM_SW   = 3,
    parameter logic [NUM_SW-1:0] PWM_MASK = 3'b011
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        dev_mode_i,
    input logic [NUM_SW-1:0] en_bits_i,
    input logic              wr_stb_i,
    input logic              pwm_i,
    input logic [NUM_SW-1:0] ot_i,
    input logic [NUM_SW-1:0] gate_o,
    input logic              ot_stat_o,
    input logic              fault_evt_o
);

    a_r3_off_outside_normal: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_mode_i == 3'd1 || dev_mode_i == 3'd2) |-> gate_o == '0);

    a_r1_pwm_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_i |-> (gate_o & PWM_MASK) == '0);

    a_r2_gate_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o & ~en_bits_i) == '0);

    a_r4_fault_blocks_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o & ot_i) == '0);

    a_r7_fault_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        ot_i != '0 |=> ot_stat_o);

    a_r5_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ot_stat_o) |-> $past(wr_stb_i));

    a_r8_event_implies_latched: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt_o |-> ot_stat_o);

endmodule

bind hs_gate_ctrl hs_gate_ctrl_chk #(
    .NUM_SW   (NUM_SW),
    .PWM_MASK (PWM_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_mode_i  (dev_mode_i),
    .en_bits_i   (en_bits_i),
    .wr_stb_i    (wr_stb_i),
    .pwm_i       (pwm_i),
    .ot_i        (ot_i),
    .gate_o      (gate_o),
    .ot_stat_o   (ot_stat_o),
    .fault_evt_o (fault_evt_o)
);

// File: tb/hs_gate_ctrl_tb.sv
module hs_gate_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] dev_mode_i;
    logic [2:0] en_bits_i;
    logic       wr_stb_i;
    logic       pwm_i;
    logic [2:0] ot_i;
    logic [2:0] gate_o;
    logic       ot_stat_o;
    logic       fault_evt_o;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    logic [2:0] m_trip = '0;
    logic       m_evt  = 1'b0;

    always #5 clk = ~clk;

    hs_gate_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_mode_i  (dev_mode_i),
        .en_bits_i   (en_bits_i),
        .wr_stb_i    (wr_stb_i),
        .pwm_i       (pwm_i),
        .ot_i        (ot_i),
        .gate_o      (gate_o),
        .ot_stat_o   (ot_stat_o),
        .fault_evt_o (fault_evt_o)
    );

    function automatic logic [2:0] exp_gate(input logic [2:0] md, input logic [2:0] en,
                                            input logic pw, input logic [2:0] ot,
                                            input logic [2:0] trip);
        logic [2:0] g;
        logic allow;
        allow = (md == 3'd1) || (md == 3'd2);
        for (int k = 0; k < 3; k++) begin
            g[k] = allow && en[k] && !ot[k] && !trip[k] && ((k == 2) ? 1'b1 : pw);
        end
        return g;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic [2:0] md, input logic [2:0] en, input logic wr,
                         input logic pw, input logic [2:0] ot, input string tag);
        logic [2:0] n_trip;
        logic       n_evt;
        dev_mode_i = md;
        en_bits_i  = en;
        wr_stb_i   = wr;
        pwm_i      = pw;
        ot_i       = ot;
        #1;
        chk({tag, " gate"}, {5'd0, gate_o}, {5'd0, exp_gate(md, en, pw, ot, m_trip)});
        chk({tag, " R7 status"}, {7'd0, ot_stat_o}, {7'd0, |m_trip});
        chk({tag, " R8 event"}, {7'd0, fault_evt_o}, {7'd0, m_evt});
        n_trip = m_trip;
        n_evt  = 1'b0;
        for (int k = 0; k < 3; k++) begin
            if (!m_trip[k]) begin
                if (ot[k]) begin
                    n_trip[k] = 1'b1;
                    n_evt     = 1'b1;
                end
            end else if (wr && en[k]) begin
                if (ot[k]) n_evt = 1'b1;
                else       n_trip[k] = 1'b0;
            end
        end
        @(posedge clk);
        #1;
        m_trip = n_trip;
        m_evt  = n_evt;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [2:0] md, en, ot;
        logic       wr, pw;
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        dev_mode_i = '0; en_bits_i = '0; wr_stb_i = 1'b0; pwm_i = 1'b0; ot_i = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 reset state
        cycle(3'd2, 3'b000, 1'b0, 1'b0, 3'b000, "R9 reset");
        // R1 R2 gating by pwm
        cycle(3'd2, 3'b111, 1'b0, 1'b1, 3'b000, "R1 pwm high");
        cycle(3'd2, 3'b111, 1'b0, 1'b0, 3'b000, "R2 pwm low");
        cycle(3'd1, 3'b101, 1'b0, 1'b1, 3'b000, "R1 normal request");
        // R3 blocked modes
        cycle(3'd0, 3'b111, 1'b0, 1'b1, 3'b000, "R3 reset mode");
        cycle(3'd3, 3'b111, 1'b0, 1'b1, 3'b000, "R3 stop mode");
        cycle(3'd4, 3'b111, 1'b0, 1'b1, 3'b000, "R3 sleep mode");
        cycle(3'd7, 3'b111, 1'b0, 1'b1, 3'b000, "R3 unused code");
        // R4 trip on channel 0, R8 event, R10 others unaffected
        cycle(3'd2, 3'b111, 1'b0, 1'b1, 3'b001, "R4 trip ch0");
        cycle(3'd2, 3'b111, 1'b0, 1'b1, 3'b000, "R4 latched after fault gone");
        cycle(3'd2, 3'b111, 1'b0, 1'b1, 3'b000, "R8 single pulse");
        // R5 no clear without strobe or with zero bit
        cycle(3'd2, 3'b110, 1'b1, 1'b1, 3'b000, "R5 write zero");
        cycle(3'd2, 3'b111, 1'b0, 1'b1, 3'b000, "R5 no strobe");
        // R6 rewrite under fault
        cycle(3'd2, 3'b111, 1'b1, 1'b1, 3'b001, "R6 rewrite under fault");
        cycle(3'd2, 3'b111, 1'b0, 1'b1, 3'b001, "R6 event after retrip");
        cycle(3'd2, 3'b111, 1'b0, 1'b1, 3'b001, "R8 held fault no event");
        // R10 trip ch2 while ch0 latched
        cycle(3'd2, 3'b111, 1'b0, 1'b1, 3'b100, "R10 trip ch2");
        // R5 clean rearm of ch0 and ch2
        cycle(3'd2, 3'b111, 1'b1, 1'b1, 3'b000, "R5 rearm");
        cycle(3'd2, 3'b111, 1'b0, 1'b1, 3'b000, "R5 after rearm");
        cycle(3'd2, 3'b111, 1'b0, 1'b0, 3'b000, "R1 pwm after rearm");

        for (int i = 0; i < 4000; i++) begin
            md = ($urandom % 4 != 0) ? 3'(1 + $urandom % 2) : 3'($urandom % 8);
            en = 3'($urandom);
            wr = ($urandom % 5 == 0);
            pw = 1'($urandom);
            ot = '0;
            for (int k = 0; k < 3; k++) ot[k] = ($urandom % 14 == 0);
            cycle(md, en, wr, pw, ot, "R1/R2/R3/R4/R5/R6/R8/R10 random");
        end
        finish_run();
    end

endmodule